// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block collects 64 interrupt request lines and presents them to a processor through a small word-addressed register bus. A control byte for each line sets three things: whether the line is enabled, how it triggers (active-high level, rising edge or falling edge), and where its request goes. A request can go to the normal interrupt output, the fast interrupt output, or one of six auxiliary request outputs.

Edge events are held in status words until software clears them with a write-one-to-clear. For level lines the status bit follows the input line. A priority resolver serves the normal interrupt output. It finds the winning source among the enabled, pending sources that are routed there and publishes that source's index in a vector register. When nothing is pending the vector reads the index of the last source. The top status bit tells that idle value apart from a real request on the last source.

Two priority modes are available. In fixed mode the lowest index wins. In rotating mode each vector read that reports a source makes that source the lowest priority for the next search.

Top module: `intc_vec64`

## Requirements
- R1: After reset every control byte reads 0 (disabled, level, routed to the normal output), the vector at 0x00 reads 63, both priority registers read 0, and irq_o, fiq_o and aux_o are all low.
- R2: A source whose control bit 3 is clear never raises any output and is never reported by the vector. Its status bit still shows the line level or the latched edge.
- R3: With trigger bits 6:5 = 00, the status bit of a source equals its input line. An enabled source is pending while the line is high.
- R4: With control bit 5 set, a 0-to-1 transition of the line latches the status bit. The bit stays set after the line falls.
- R5: With bit 6 set and bit 5 clear, a 1-to-0 transition latches the status bit. A rising transition latches nothing.
- R6: Source n appears in the status word at 0x80 (n < 32) or 0x84 (n >= 32), at bit n mod 32. Writing a 1 there clears a latched edge. Writing a 0 leaves the bit unchanged.
- R7: Control bits 2:0 route a pending enabled source. Code 0 goes to irq_o, code 1 to fiq_o, and codes 2 to 7 go to aux_o bit (code - 2).
- R8: The vector register at 0x00 returns, in bits 5:0, the index of the winning pending enabled source routed to irq_o. In fixed mode the lowest index wins. With nothing pending it reads 63, and bit 31 of 0x84 is 0 unless source 63 is really pending.
- R9: The outputs and the vector are registered. They change on the first clock edge after a change in pending state.
- R10: In the register at 0x20, bit 6 selects rotating priority and bits 5:0 hold the last reported index, writable by software. With rotation on, a read of 0x00 while a source is reported loads that index into bits 5:0. The next search then starts at the index after it and wraps.
- R11: The control byte of source n sits at byte address 0x40 + n. The word at 0x40 + 4k holds source 4k + j in bits 8j+7:8j.
- R12: The register at 0x24 stores bits 6:0 as written and reads them back. It has no effect on the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, needed for the rotation update |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_lines | input | 64 | Interrupt request lines, synchronous to clk |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| aux_o | output | 6 | Auxiliary request outputs |

## Verification
The assertions take for granted three things about the inputs. The request lines are already synchronous to clk. At most one bus access happens per cycle. A vector read is never issued in the same cycle as a write to the priority register, so the rotation pointer has a single source of update at any edge. The stimulus drives every input on the falling clock edge and keeps the lines low through reset, so no edge is detected at reset release. Bus strobes last exactly one cycle, and reads are issued only while no write is in flight. The sweeps walk each of the 64 sources through level and rising-edge mode, all eight routing codes, and chosen priority pairs including the wrap of the rotating search.

// File: rtl/intc_vec64_pkg.sv
package intc_vec64_pkg;

    // trigger field: bit 0 = rising, bit 1 = falling, 00 = level high
    typedef enum logic [1:0] {
        TRIG_LEVEL     = 2'b00,
        TRIG_RISE      = 2'b01,
        TRIG_FALL      = 2'b10,
        TRIG_RISE_BOTH = 2'b11
    } trig_e;

    typedef struct packed {
        logic       spare_hi;
        trig_e      trig;
        logic       spare_lo;
        logic       en;
        logic [2:0] dest;
    } ctrl_t;

    localparam logic [2:0] DEST_IRQ      = 3'd0;
    localparam logic [2:0] DEST_FIQ      = 3'd1;
    localparam int         DEST_AUX_BASE = 2;

    localparam int ADDR_VEC      = 'h00;
    localparam int ADDR_IRQ_PRIO = 'h20;
    localparam int ADDR_FIQ_PRIO = 'h24;
    localparam int ADDR_CTRL     = 'h40;
    localparam int ADDR_STAT     = 'h80;

endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
    import intc_vec64_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_i,
    input  trig_e trig_i,
    input  logic  clr_i,
    output logic  status_o
);

    logic prev_q;
    logic latch_q;
    logic rise;
    logic fall;
    logic evt;

    assign rise = line_i & ~prev_q;
    assign fall = ~line_i & prev_q;

    always_comb begin
        unique case (trig_i)
            TRIG_LEVEL:     evt = 1'b0;
            TRIG_RISE:      evt = rise;
            TRIG_FALL:      evt = fall;
            TRIG_RISE_BOTH: evt = rise;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= line_i;
            if (evt)
                latch_q <= 1'b1;
            else if (clr_i)
                latch_q <= 1'b0;
        end
    end

    assign status_o = (trig_i == TRIG_LEVEL) ? line_i : latch_q;

    // R4: a latched edge survives until a clear arrives
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !clr_i) |=> latch_q);

    // R6: a one written to the status bit removes the event
    assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt) |=> !latch_q);

endmodule

// File: rtl/intc_resolver.sv
module intc_resolver #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         pend_i,
    input  logic                 rot_en_i,
    input  logic [$clog2(N)-1:0] ptr_i,
    output logic                 any_o,
    output logic [$clog2(N)-1:0] win_o
);

    localparam int IW = $clog2(N);

    logic [IW-1:0] base;
    logic [N-1:0]  rot;
    logic [IW-1:0] idx;

    assign base = rot_en_i ? IW'(ptr_i + 1'b1) : '0;

    always_comb begin
        for (int i = 0; i < N; i++)
            rot[i] = pend_i[IW'(i + int'(base))];
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (rot[i]) idx = IW'(i);
    end

    assign any_o = |pend_i;
    assign win_o = IW'(base + idx);

    // R8: the reported winner is really pending
    assert_winner_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> pend_i[win_o]);

    // R8: fixed mode always prefers source 0
    assert_fixed_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_en_i && pend_i[0]) |-> (win_o == '0));

endmodule

// File: rtl/intc_vec64.sv
module intc_vec64
    import intc_vec64_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  irq_lines,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [5:0]        aux_o
);

    localparam int IW       = $clog2(N_SRC);
    localparam int N_WORDS  = N_SRC / DATA_W;
    localparam int N_AUX    = 6;
    localparam int BPW      = DATA_W / 8;
    localparam logic [IW-1:0] IDLE_VEC = IW'(N_SRC - 1);

    ctrl_t [N_SRC-1:0] ctrl_q;
    logic [N_SRC-1:0]  stat;
    logic [N_SRC-1:0]  clr;
    logic [N_SRC-1:0]  pend_all;
    logic [N_SRC-1:0]  irq_pend;
    logic [N_SRC-1:0]  fiq_pend;
    logic [N_AUX-1:0][N_SRC-1:0] aux_pend;

    logic          rot_q;
    logic [IW-1:0] ptr_q;
    logic [6:0]    fiq_prio_q;
    logic [IW-1:0] vec_q;
    logic          vec_valid_q;
    logic          irq_q, fiq_q;
    logic [N_AUX-1:0] aux_q;
    logic          any_irq;
    logic [IW-1:0] win;

    // control bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr) begin
            for (int i = 0; i < N_SRC; i++)
                if (bus_addr == ADDR_W'(ADDR_CTRL + (i / BPW) * BPW))
                    ctrl_q[i] <= bus_wdata[8*(i%BPW) +: 8];
        end
    end

    // per-source trigger cells
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign clr[g] = bus_wr
            && (bus_addr == ADDR_W'(ADDR_STAT + 4 * (g / DATA_W)))
            && bus_wdata[g % DATA_W];

        intc_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_i   (irq_lines[g]),
            .trig_i   (ctrl_q[g].trig),
            .clr_i    (clr[g]),
            .status_o (stat[g])
        );

        assign pend_all[g] = stat[g] & ctrl_q[g].en;
        assign irq_pend[g] = pend_all[g] && (ctrl_q[g].dest == DEST_IRQ);
        assign fiq_pend[g] = pend_all[g] && (ctrl_q[g].dest == DEST_FIQ);

        for (genvar k = 0; k < N_AUX; k++) begin : g_aux
            assign aux_pend[k][g] = pend_all[g]
                && (ctrl_q[g].dest == 3'(k + DEST_AUX_BASE));
        end
    end

    intc_resolver #(.N(N_SRC)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (irq_pend),
        .rot_en_i (rot_q),
        .ptr_i    (ptr_q),
        .any_o    (any_irq),
        .win_o    (win)
    );

    // priority registers and rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_q      <= 1'b0;
            ptr_q      <= '0;
            fiq_prio_q <= '0;
        end else if (bus_wr && bus_addr == ADDR_W'(ADDR_IRQ_PRIO)) begin
            rot_q <= bus_wdata[6];
            ptr_q <= bus_wdata[IW-1:0];
        end else if (bus_wr && bus_addr == ADDR_W'(ADDR_FIQ_PRIO)) begin
            fiq_prio_q <= bus_wdata[6:0];
        end else if (bus_rd && bus_addr == ADDR_W'(ADDR_VEC) && rot_q && vec_valid_q) begin
            ptr_q <= vec_q;
        end
    end

    // registered outputs and vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q       <= 1'b0;
            fiq_q       <= 1'b0;
            aux_q       <= '0;
            vec_q       <= IDLE_VEC;
            vec_valid_q <= 1'b0;
        end else begin
            irq_q       <= |irq_pend;
            fiq_q       <= |fiq_pend;
            for (int k = 0; k < N_AUX; k++)
                aux_q[k] <= |aux_pend[k];
            vec_q       <= any_irq ? win : IDLE_VEC;
            vec_valid_q <= any_irq;
        end
    end

    assign irq_o = irq_q;
    assign fiq_o = fiq_q;
    assign aux_o = aux_q;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_VEC))
            bus_rdata[IW-1:0] = vec_q;
        if (bus_addr == ADDR_W'(ADDR_IRQ_PRIO))
            bus_rdata[IW:0] = {rot_q, ptr_q};
        if (bus_addr == ADDR_W'(ADDR_FIQ_PRIO))
            bus_rdata[6:0] = fiq_prio_q;
        for (int i = 0; i < N_SRC; i++)
            if (bus_addr == ADDR_W'(ADDR_CTRL + (i / BPW) * BPW))
                bus_rdata[8*(i%BPW) +: 8] = ctrl_q[i];
        for (int w = 0; w < N_WORDS; w++)
            if (bus_addr == ADDR_W'(ADDR_STAT + 4 * w))
                bus_rdata = stat[DATA_W*w +: DATA_W];
    end

    // R9: a reported vector always comes with the request line
    assert_vec_implies_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_q != IDLE_VEC) |-> irq_o);

    // R7: the fast request rises only after a fast-routed source was pending
    assert_fiq_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_o) |-> $past(|fiq_pend));

endmodule

// File: tb/intc_vec64_test.sv
module intc_vec64_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_lines = '0;
    logic        irq_o, fiq_o;
    logic [5:0]  aux_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [7:0] m_ctrl [64];

    always #10 clk = ~clk;

    intc_vec64 uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines), .irq_o(irq_o), .fiq_o(fiq_o), .aux_o(aux_o)
    );

    task automatic step(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_ctrl(int n, logic [7:0] v);
        int w;
        m_ctrl[n] = v;
        w = n & ~3;
        wr(8'(8'h40 + w), {m_ctrl[w+3], m_ctrl[w+2], m_ctrl[w+1], m_ctrl[w]});
    endtask

    task automatic stat_bit(int n, output logic b);
        logic [31:0] d;
        rd(8'(8'h80 + 4 * (n / 32)), d);
        b = d[n % 32];
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog got timeout exp completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        logic b;
        for (int i = 0; i < 64; i++) m_ctrl[i] = 8'h00;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        for (int w = 0; w < 16; w++) begin
            rd(8'(8'h40 + 4 * w), d); check("R1 ctrl", d, 0);
        end
        rd(8'h00, d); check("R1 vec", d, 63);
        rd(8'h20, d); check("R1 irq prio", d, 0);
        rd(8'h24, d); check("R1 fiq prio", d, 0);
        check("R1 outs", {aux_o, fiq_o, irq_o}, 0);

        // R11: byte placement inside the control words
        wr(8'h44, 32'h0403_0201);
        rd(8'h44, d); check("R11 word", d, 32'h0403_0201);
        set_ctrl(6, 8'h08);
        rd(8'h44, d); check("R11 byte", d, 32'h0008_0000);
        set_ctrl(6, 8'h00);

        // R3 R8 R9: level sweep over all sources
        for (int n = 0; n < 64; n++) begin
            set_ctrl(n, 8'h08);
            irq_lines[n] = 1'b1;
            #1 check("R9 not yet", irq_o, 0);
            step(1);
            check("R9 irq", irq_o, 1);
            rd(8'h00, d); check("R8 vec", d, n);
            stat_bit(n, b); check("R3 status", b, 1);
            irq_lines[n] = 1'b0;
            step(1);
            check("R3 drop", irq_o, 0);
            set_ctrl(n, 8'h00);
        end

        // R4 R6: rising edge sweep with clear
        for (int n = 0; n < 64; n++) begin
            set_ctrl(n, 8'h28);
            irq_lines[n] = 1'b1; step(1);
            irq_lines[n] = 1'b0; step(1);
            stat_bit(n, b); check("R4 latched", b, 1);
            rd(8'h00, d); check("R4 vec", d, n);
            wr(8'(8'h80 + 4 * (n / 32)), 32'h0);
            stat_bit(n, b); check("R6 zero write", b, 1);
            wr(8'(8'h80 + 4 * (n / 32)), 32'h1 << (n % 32));
            stat_bit(n, b); check("R6 cleared", b, 0);
            step(1);
            check("R6 irq off", irq_o, 0);
            set_ctrl(n, 8'h00);
        end

        // R5: falling edge
        foreach (d[k]) begin end
        for (int j = 0; j < 4; j++) begin
            int n;
            n = (j == 0) ? 0 : (j == 1) ? 31 : (j == 2) ? 32 : 63;
            set_ctrl(n, 8'h48);
            irq_lines[n] = 1'b1; step(1);
            stat_bit(n, b); check("R5 no rise", b, 0);
            irq_lines[n] = 1'b0; step(2);
            stat_bit(n, b); check("R5 fall", b, 1);
            check("R5 irq", irq_o, 1);
            wr(8'(8'h80 + 4 * (n / 32)), 32'h1 << (n % 32));
            set_ctrl(n, 8'h00);
            step(1);
        end

        // R2: disabled sources
        irq_lines[9] = 1'b1; step(1);
        stat_bit(9, b); check("R2 status", b, 1);
        check("R2 irq", irq_o, 0);
        rd(8'h00, d); check("R2 vec", d, 63);
        irq_lines[9] = 1'b0;
        set_ctrl(40, 8'h20);
        irq_lines[40] = 1'b1; step(1); irq_lines[40] = 1'b0; step(2);
        stat_bit(40, b); check("R2 latch", b, 1);
        check("R2 irq edge", irq_o, 0);
        wr(8'h84, 32'h100);
        set_ctrl(40, 8'h00);

        // R8: fixed priority pairs
        for (int a = 0; a < 63; a += 7) begin
            for (int c = a + 1; c < 64; c += 9) begin
                set_ctrl(a, 8'h08); set_ctrl(c, 8'h08);
                irq_lines[a] = 1'b1; irq_lines[c] = 1'b1;
                step(1);
                rd(8'h00, d); check("R8 pair", d, a);
                irq_lines[a] = 1'b0; irq_lines[c] = 1'b0;
                set_ctrl(a, 8'h00); set_ctrl(c, 8'h00);
            end
        end
        step(1);
        rd(8'h84, d); check("R8 idle bit31", d[31], 0);
        rd(8'h00, d); check("R8 idle vec", d, 63);
        set_ctrl(63, 8'h08); irq_lines[63] = 1'b1; step(1);
        rd(8'h84, d); check("R8 src63 bit31", d[31], 1);
        rd(8'h00, d); check("R8 src63 vec", d, 63);
        check("R8 src63 irq", irq_o, 1);
        irq_lines[63] = 1'b0; set_ctrl(63, 8'h00);

        // R7: routing codes
        for (int dc = 0; dc < 8; dc++) begin
            set_ctrl(5, 8'(8'h08 | dc));
            irq_lines[5] = 1'b1; step(1);
            check("R7 irq", irq_o, (dc == 0) ? 1 : 0);
            check("R7 fiq", fiq_o, (dc == 1) ? 1 : 0);
            check("R7 aux", aux_o, (dc >= 2) ? (32'h1 << (dc - 2)) : 0);
            irq_lines[5] = 1'b0; step(1);
        end
        set_ctrl(5, 8'h00);

        // R10: rotating priority
        wr(8'h20, 32'h40);
        rd(8'h20, d); check("R10 mode", d, 32'h40);
        set_ctrl(3, 8'h08); set_ctrl(10, 8'h08);
        irq_lines[3] = 1'b1; irq_lines[10] = 1'b1;
        step(1);
        rd(8'h00, d); check("R10 first", d, 3);
        step(1);
        rd(8'h20, d); check("R10 ptr", d, 32'h43);
        rd(8'h00, d); check("R10 second", d, 10);
        step(1);
        rd(8'h00, d); check("R10 wrap", d, 3);
        wr(8'h20, 32'h40 | 5); step(1);
        rd(8'h00, d); check("R10 sw ptr", d, 10);
        wr(8'h20, 32'h0); step(1);
        rd(8'h00, d); check("R10 fixed again", d, 3);

        // R12: fast priority register
        wr(8'h24, 32'hFF);
        rd(8'h24, d); check("R12 readback", d, 32'h7F);
        step(1);
        rd(8'h00, d); check("R12 no effect", d, 3);
        irq_lines = '0;

        summary();
    end

endmodule